// File: doc/BRIEF.md
# TPM Register Hardware-Return Controller

This block serves the device end of a TPM link carried over SPI mode 0. It decodes the 4-byte header that opens each transaction. Reads of a small, parameterised set of status-style registers are answered straight from hardware shadow copies. Firmware does not have to run for those reads. Waits are signalled in-band: the device holds MISO low through the last header bit and through any wait bytes. It releases the host by returning a 1 in the final bit of a byte, and the data bytes start with the byte after that.

A host write to one of these registers is handled in hardware. Each register carries its own mask of settable bits. The write sets a bit only when the written byte holds exactly one set bit inside that mask. A write to the access-control register also clears that register's valid-status bit. Any such write immediately marks all shadows stale, raises a sticky event with an interrupt, and records the address and the data byte. Firmware then has no deadline. Every following read waits until firmware has refreshed the shadows and set the ready flag again. A read of any address outside the set is always left waiting for firmware handling.

Top module: `tpm_hwret_ctrl`

## Requirements
- R1: The header is four bytes, most significant bit first, with MOSI sampled on SCK rising edges. In byte 0, bit 7 set means read and bits 5:0 give the transfer length minus one. Bytes 1 to 3 give a 24-bit address, high byte first. A read returns exactly that many data bytes, and MISO is 0 for any bytes clocked after them.
- R2: MISO changes only after SCK falling edges. It is 0 for all header bits. Every wait byte reads 0x00, except the byte that ends the wait, which reads 0x01. Data bytes follow that byte, most significant bit first.
- R3: While ready is set, a read of a hardware-returned register completes after exactly one wait byte. Every data byte of that read carries the register's shadow value.
- R4: A host write to a hardware-returned register clears the ready flag. Only the first data byte of the write is used.
- R5: While ready is clear, a read of a hardware-returned register keeps returning 0x00 wait bytes for as long as the host clocks. It is released in the first wait byte whose last bit is driven after firmware sets ready.
- R6: On a host write, a register bit is set only when the written byte, masked by that register's settable mask, has exactly one bit set; that bit is then ORed in. Any other pattern leaves the settable bits unchanged. Host writes never clear settable bits and never touch bits outside the mask. Default masks: 0x26 for the access register at 0xD40000 and 0x64 for the status register at 0xD40018.
- R7: Every host write to the access register clears its bit 7, the register-valid status, whatever the data pattern.
- R8: A host write to a hardware-returned register sets a sticky event flag that drives fw_irq high. It also captures the full 24-bit address and the data byte.
- R9: Firmware map on fw_addr, with NREG = 2: 0 and 1 are the shadows, which a firmware write overwrites completely. 2 is control: a write with bit 0 set sets ready, and a write with bit 1 set clears the event; a read returns {event, ready} in bits 1:0. 3 is the captured address and 4 the captured data byte.
- R10: A read of an address outside the set is held in wait bytes even while ready is set. A write to such an address is released after one wait byte and changes no register, flag or event.
- R11: A host write to any address is released after exactly one wait byte.
- R12: Raising chip-select in the middle of a transaction returns the framer to header decode. It changes no shadow, flag or capture, and the next transaction decodes normally.
- R13: After reset, shadows, ready, event, captures, fw_irq and MISO are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI clock, mode 0 |
| spi_csb | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Host to device serial data |
| spi_miso | output | 1 | Device to host serial data, wait flag included |
| fw_we | input | 1 | Firmware write strobe |
| fw_addr | input | $clog2(NREG+3) | Firmware register index |
| fw_wdata | input | 8 | Firmware write data |
| fw_rdata | output | 24 | Firmware read data for fw_addr |
| fw_irq | output | 1 | Sticky host-write event |

## Verification
The set-bit rule is swept over every single-bit byte and a spread of multi-bit bytes on both registers. The expected value is computed arithmetically from the masks. This separates the one-allowed-bit case from the cases where no allowed bit is set, two allowed bits are set, or only disallowed bits are set. Reads are tried in four situations: with valid shadows, with stale shadows released by firmware in the middle of the wait, on an address outside the set, and as a multi-byte transfer. Together these separate the single-wait path, the indefinite hold, the permanent hold and the length field. An aborted write and a write to an address outside the set show that the framing and state are untouched when no valid write completes.

// File: rtl/tpm_hwret_pkg.sv
package tpm_hwret_pkg;
   localparam int ADDR_W   = 24;
   localparam int BYTE_W   = 8;
   localparam int HDR_BITS = 32;

   typedef enum logic [1:0] {
      FR_HDR  = 2'd0,
      FR_WAIT = 2'd1,
      FR_DATA = 2'd2,
      FR_SKIP = 2'd3
   } frame_st_e;
endpackage

// File: rtl/tpm_spi_sync.sv
module tpm_spi_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic csb,
   input  logic mosi,
   output logic sck_rise,
   output logic sck_fall,
   output logic cs_act,
   output logic mosi_s
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tpm_spi_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sck_p, cs_p, mo_p;
   logic              sck_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_p <= '0;
         cs_p  <= '1;
         mo_p  <= '0;
         sck_d <= 1'b0;
      end else begin
         sck_p <= {sck_p[STAGES-2:0], sck};
         cs_p  <= {cs_p[STAGES-2:0], csb};
         mo_p  <= {mo_p[STAGES-2:0], mosi};
         sck_d <= sck_p[STAGES-1];
      end
   end

   assign cs_act   = ~cs_p[STAGES-1];
   assign mosi_s   = mo_p[STAGES-1];
   assign sck_rise = cs_act &  sck_p[STAGES-1] & ~sck_d;
   assign sck_fall = cs_act & ~sck_p[STAGES-1] &  sck_d;
endmodule

// File: rtl/tpm_shadow_bank.sv
module tpm_shadow_bank
   import tpm_hwret_pkg::*;
#(
   parameter int                       NREG      = 2,
   parameter logic [NREG*ADDR_W-1:0]   REG_ADDR  = '0,
   parameter logic [NREG*BYTE_W-1:0]   REG_MASK  = '0,
   parameter int                       ACC_IDX   = 0,
   parameter int                       VSTS_BIT  = 7,
   localparam int                      IW        = (NREG > 1) ? $clog2(NREG) : 1,
   localparam int                      FW_AW     = $clog2(NREG + 3)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lookup_addr,
   output logic              hit,
   output logic [IW-1:0]     hit_idx,
   input  logic [IW-1:0]     rd_idx,
   output logic [BYTE_W-1:0] rd_val,
   input  logic              host_we,
   input  logic [IW-1:0]     host_idx,
   input  logic [BYTE_W-1:0] host_data,
   output logic              valid,
   output logic              evt,
   input  logic              fw_we,
   input  logic [FW_AW-1:0]  fw_addr,
   input  logic [BYTE_W-1:0] fw_wdata,
   output logic [ADDR_W-1:0] fw_rdata
);
   localparam logic [FW_AW-1:0] CTRL_A = FW_AW'(NREG);
   localparam logic [FW_AW-1:0] CAPA_A = FW_AW'(NREG + 1);
   localparam logic [FW_AW-1:0] CAPD_A = FW_AW'(NREG + 2);

   logic [NREG-1:0]        match_v;
   logic [NREG*BYTE_W-1:0] shadow_flat;
   logic [ADDR_W-1:0]      cap_a;
   logic [BYTE_W-1:0]      cap_d;
   logic                   ctrl_wr;

   assign ctrl_wr = fw_we && (fw_addr == CTRL_A);

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      localparam logic [BYTE_W-1:0] MASK  = REG_MASK[r*BYTE_W +: BYTE_W];
      localparam logic [BYTE_W-1:0] VMASK = (r == ACC_IDX) ? (BYTE_W'(1) << VSTS_BIT) : '0;
      localparam logic [BYTE_W-1:0] KEEP  = ~(MASK | VMASK);

      logic [BYTE_W-1:0] q, allowed, nxt;
      logic              host_sel;

      assign match_v[r] = (lookup_addr == REG_ADDR[r*ADDR_W +: ADDR_W]);
      assign allowed    = host_data & MASK;
      assign host_sel   = host_we && (host_idx == IW'(r));

      always_comb begin
         nxt = q;
         if ($countones(allowed) == 1) nxt = q | allowed;
         nxt = nxt & ~VMASK;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   q <= '0;
         else if (host_sel)                            q <= nxt;
         else if (fw_we && (fw_addr == FW_AW'(r)))     q <= fw_wdata;
      end

      assign shadow_flat[r*BYTE_W +: BYTE_W] = q;

      // R6
      host_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         host_sel |=> ((q & KEEP) == $past(q & KEEP)) && ((q & MASK) == ($past(q) & MASK | (q & MASK))));

      if (r == ACC_IDX) begin : g_acc
         // R7
         acc_vsts_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            host_sel |=> !q[VSTS_BIT]);
      end
   end

   assign hit = |match_v;

   always_comb begin
      hit_idx = '0;
      for (int r = 0; r < NREG; r++)
         if (match_v[r]) hit_idx = IW'(r);
   end

   always_comb begin
      rd_val = '0;
      for (int r = 0; r < NREG; r++)
         if (rd_idx == IW'(r)) rd_val = shadow_flat[r*BYTE_W +: BYTE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         evt   <= 1'b0;
         cap_a <= '0;
         cap_d <= '0;
      end else if (host_we) begin
         valid <= 1'b0;
         evt   <= 1'b1;
         cap_a <= lookup_addr;
         cap_d <= host_data;
      end else if (ctrl_wr) begin
         if (fw_wdata[0]) valid <= 1'b1;
         if (fw_wdata[1]) evt   <= 1'b0;
      end
   end

   always_comb begin
      fw_rdata = '0;
      if (fw_addr == CTRL_A)      fw_rdata = {{(ADDR_W-2){1'b0}}, evt, valid};
      else if (fw_addr == CAPA_A) fw_rdata = cap_a;
      else if (fw_addr == CAPD_A) fw_rdata = {{(ADDR_W-BYTE_W){1'b0}}, cap_d};
      else
         for (int r = 0; r < NREG; r++)
            if (fw_addr == FW_AW'(r))
               fw_rdata = {{(ADDR_W-BYTE_W){1'b0}}, shadow_flat[r*BYTE_W +: BYTE_W]};
   end

   // R4
   stale_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_we |=> !valid);

   // R8
   event_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && !(ctrl_wr && fw_wdata[1])) |=> evt);
endmodule

// File: rtl/tpm_hwret_ctrl.sv
module tpm_hwret_ctrl
   import tpm_hwret_pkg::*;
#(
   parameter int                     NREG        = 2,
   parameter logic [NREG*ADDR_W-1:0] REG_ADDR    = {24'hD40018, 24'hD40000},
   parameter logic [NREG*BYTE_W-1:0] REG_MASK    = {8'h64, 8'h26},
   parameter int                     ACC_IDX     = 0,
   parameter int                     VSTS_BIT    = 7,
   parameter int                     SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       spi_sck,
   input  logic                       spi_csb,
   input  logic                       spi_mosi,
   output logic                       spi_miso,
   input  logic                       fw_we,
   input  logic [$clog2(NREG+3)-1:0]  fw_addr,
   input  logic [BYTE_W-1:0]          fw_wdata,
   output logic [ADDR_W-1:0]          fw_rdata,
   output logic                       fw_irq
);
   localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

   if (NREG < 1) begin : g_bad_nreg
      $error("tpm_hwret_ctrl: NREG must be at least 1");
   end
   if (ACC_IDX >= NREG || VSTS_BIT >= BYTE_W) begin : g_bad_acc
      $error("tpm_hwret_ctrl: access register index or status bit out of range");
   end
   if (REG_MASK[ACC_IDX*BYTE_W + VSTS_BIT]) begin : g_bad_mask
      $error("tpm_hwret_ctrl: valid-status bit must not be host settable");
   end

   logic              rise, fall, cs_act, mosi_s;
   logic [HDR_BITS-1:0] hdr_q;
   logic [2:0]        bit_q;
   logic [1:0]        hbyte_q;
   logic [5:0]        dcnt_q;
   logic [BYTE_W-1:0] rx_q;
   frame_st_e         st_q;
   logic              go_q, miso_q;
   logic              hit, valid, evt, host_we, rd, go;
   logic [IW-1:0]     hit_idx;
   logic [BYTE_W-1:0] rd_val;

   tpm_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .sck(spi_sck), .csb(spi_csb), .mosi(spi_mosi),
      .sck_rise(rise), .sck_fall(fall), .cs_act(cs_act), .mosi_s(mosi_s)
   );

   assign rd      = hdr_q[31];
   assign go      = !rd || (hit && valid);
   assign host_we = rise && (st_q == FR_DATA) && !rd && (bit_q == 3'd7) && hit;

   tpm_shadow_bank #(
      .NREG(NREG), .REG_ADDR(REG_ADDR), .REG_MASK(REG_MASK),
      .ACC_IDX(ACC_IDX), .VSTS_BIT(VSTS_BIT)
   ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .lookup_addr(hdr_q[ADDR_W-1:0]), .hit(hit), .hit_idx(hit_idx),
      .rd_idx(hit_idx), .rd_val(rd_val),
      .host_we(host_we), .host_idx(hit_idx), .host_data({rx_q[6:0], mosi_s}),
      .valid(valid), .evt(evt),
      .fw_we(fw_we), .fw_addr(fw_addr), .fw_wdata(fw_wdata), .fw_rdata(fw_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hdr_q   <= '0;
         bit_q   <= '0;
         hbyte_q <= '0;
         dcnt_q  <= '0;
         rx_q    <= '0;
         st_q    <= FR_HDR;
         go_q    <= 1'b0;
         miso_q  <= 1'b0;
      end else if (!cs_act) begin
         bit_q   <= '0;
         hbyte_q <= '0;
         dcnt_q  <= '0;
         st_q    <= FR_HDR;
         go_q    <= 1'b0;
         miso_q  <= 1'b0;
      end else begin
         if (rise) begin
            bit_q <= bit_q + 3'd1;
            unique case (st_q)
               FR_HDR: begin
                  hdr_q <= {hdr_q[HDR_BITS-2:0], mosi_s};
                  if (bit_q == 3'd7) begin
                     hbyte_q <= hbyte_q + 2'd1;
                     if (hbyte_q == 2'd3) st_q <= FR_WAIT;
                  end
               end
               FR_WAIT: if (bit_q == 3'd7 && go_q) st_q <= FR_DATA;
               FR_DATA: begin
                  rx_q <= {rx_q[6:0], mosi_s};
                  if (bit_q == 3'd7) begin
                     dcnt_q <= dcnt_q + 6'd1;
                     if (!rd || dcnt_q == hdr_q[29:24]) st_q <= FR_SKIP;
                  end
               end
               default: ;
            endcase
         end
         if (fall) begin
            unique case (st_q)
               FR_WAIT: begin
                  miso_q <= (bit_q == 3'd7) && go;
                  if (bit_q == 3'd7) go_q <= go;
               end
               FR_DATA: miso_q <= rd_val[3'd7 - bit_q];
               default: miso_q <= 1'b0;
            endcase
         end
      end
   end

   assign spi_miso = miso_q;
   assign fw_irq   = evt;

   // R10
   foreign_read_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == FR_WAIT && rd && !hit) |=> (st_q != FR_DATA));

   // R2
   hdr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == FR_HDR) |-> !spi_miso);

   // R5
   stale_read_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == FR_WAIT && rd && !go_q && !(rise && bit_q != 3'd7)) |=> (st_q != FR_DATA));
endmodule

// File: tb/tpm_hwret_ctrl_test.sv
module tpm_hwret_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;
   localparam logic [23:0] A_ACC = 24'hD40000;
   localparam logic [23:0] A_STS = 24'hD40018;
   localparam logic [23:0] A_OTH = 24'hD40F00;
   localparam logic [2:0]  F_ACC = 3'd0, F_STS = 3'd1, F_CTRL = 3'd2, F_CAPA = 3'd3, F_CAPD = 3'd4;
   localparam logic [7:0]  M_ACC = 8'h26, M_STS = 8'h64;

   logic        clk = 1'b0;
   logic        rst_n, sck, csb, mosi, miso, fw_we, irq;
   logic [2:0]  fw_addr;
   logic [7:0]  fw_wdata;
   logic [23:0] fw_rdata;
   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tpm_hwret_ctrl uut (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csb(csb), .spi_mosi(mosi),
      .spi_miso(miso), .fw_we(fw_we), .fw_addr(fw_addr), .fw_wdata(fw_wdata),
      .fw_rdata(fw_rdata), .fw_irq(irq)
   );

   task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic fw_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      fw_addr = a; fw_wdata = d; fw_we = 1'b1;
      @(negedge clk);
      fw_we = 1'b0;
   endtask

   task automatic fw_read(input logic [2:0] a, output logic [23:0] d);
      @(negedge clk);
      fw_addr = a;
      #1 d = fw_rdata;
   endtask

   task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
      rx = '0;
      for (int i = 7; i >= 8 - nb; i--) begin
         mosi = tx[i];
         repeat (HALF) @(negedge clk);
         rx[i] = miso;
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
      end
   endtask

   task automatic cs_on();
      csb = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic cs_off();
      repeat (HALF) @(negedge clk);
      csb = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic hdr(input bit rd, input logic [5:0] sz, input logic [23:0] a);
      logic [7:0] rx;
      logic [7:0] acc;
      acc = '0;
      spi_bits({rd, 1'b0, sz}, 8, rx); acc |= rx;
      spi_bits(a[23:16], 8, rx);       acc |= rx;
      spi_bits(a[15:8], 8, rx);        acc |= rx;
      spi_bits(a[7:0], 8, rx);         acc |= rx;
      check_eq("R2 header bits low", {24'd0, acc}, 32'd0);
   endtask

   task automatic wait_bytes(input int maxn, output int n, output bit ok);
      logic [7:0] rx;
      n = 0; ok = 1'b0;
      for (int k = 0; k < maxn; k++) begin
         spi_bits(8'h00, 8, rx);
         n++;
         checks++;
         if (rx != 8'h00 && rx != 8'h01) begin
            errors++;
            $display("FAIL R2 wait byte: actual=%0h expected=0 or 1", rx);
         end
         if (rx == 8'h01) begin
            ok = 1'b1;
            break;
         end
      end
   endtask

   task automatic host_write(input logic [23:0] a, input logic [7:0] d, output int n);
      logic [7:0] rx;
      bit ok;
      cs_on();
      hdr(1'b0, 6'd0, a);
      wait_bytes(4, n, ok);
      if (!ok) n = -1;
      spi_bits(d, 8, rx);
      cs_off();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [23:0] v, v0;
      logic [7:0]  rx, d, e;
      int n;
      bit ok;
      sck = 0; csb = 1; mosi = 0; fw_we = 0; fw_addr = 0; fw_wdata = 0; rst_n = 0;
      repeat (5) @(negedge clk);
      rst_n = 1;
      repeat (3) @(negedge clk);

      // R13 reset state
      check_eq("R13 miso", {31'd0, miso}, 0);
      check_eq("R13 irq", {31'd0, irq}, 0);
      fw_read(F_CTRL, v); check_eq("R13 ctrl", {8'd0, v}, 0);
      fw_read(F_ACC, v);  check_eq("R13 access", {8'd0, v}, 0);
      fw_read(F_STS, v);  check_eq("R13 status", {8'd0, v}, 0);
      fw_read(F_CAPA, v); check_eq("R13 capture", {8'd0, v}, 0);

      // R9 firmware preload then ready
      fw_write(F_ACC, 8'h81);
      fw_write(F_STS, 8'h10);
      fw_write(F_CTRL, 8'h01);
      fw_read(F_CTRL, v); check_eq("R9 ready set", {8'd0, v}, 1);

      // R3 single wait read
      cs_on(); hdr(1'b1, 6'd0, A_ACC); wait_bytes(4, n, ok);
      check_eq("R3 one wait byte", n, 1);
      spi_bits(8'h00, 8, rx); check_eq("R3 access data", {24'd0, rx}, 8'h81);
      cs_off();

      // R1 length field: three data bytes then zeros
      cs_on(); hdr(1'b1, 6'd2, A_STS); wait_bytes(4, n, ok);
      check_eq("R3 status one wait", n, 1);
      for (int k = 0; k < 3; k++) begin
         spi_bits(8'h00, 8, rx); check_eq("R1 status data byte", {24'd0, rx}, 8'h10);
      end
      spi_bits(8'h00, 8, rx); check_eq("R1 past transfer end", {24'd0, rx}, 0);
      cs_off();

      // R4 R6 R7 R8 R11 host write
      host_write(A_ACC, 8'h02, n);
      check_eq("R11 write one wait", n, 1);
      fw_read(F_ACC, v);  check_eq("R6 access set bit", {8'd0, v}, 8'h03);
      fw_read(F_CTRL, v); check_eq("R4 stale after write", {8'd0, v}, 2);
      check_eq("R8 irq", {31'd0, irq}, 1);
      fw_read(F_CAPA, v); check_eq("R8 captured address", {8'd0, v}, A_ACC);
      fw_read(F_CAPD, v); check_eq("R8 captured data", {8'd0, v}, 8'h02);

      // R5 held read released by firmware
      cs_on(); hdr(1'b1, 6'd0, A_ACC); wait_bytes(3, n, ok);
      check_eq("R5 held while stale", {31'd0, ok}, 0);
      fw_write(F_CTRL, 8'h01);
      wait_bytes(4, n, ok);
      check_eq("R5 released after ready", n, 1);
      spi_bits(8'h00, 8, rx); check_eq("R5 data after release", {24'd0, rx}, 8'h03);
      cs_off();

      // R9 event clear leaves ready
      fw_write(F_CTRL, 8'h02);
      fw_read(F_CTRL, v); check_eq("R9 event cleared", {8'd0, v}, 1);
      check_eq("R8 irq cleared", {31'd0, irq}, 0);

      // R6 R7 sweep of the set-bit rule
      for (int k = 0; k < 40; k++) begin
         d = (k < 8) ? 8'(1 << k) : 8'((k * 37) & 255);
         fw_write(F_STS, 8'h00); fw_write(F_CTRL, 8'h03);
         host_write(A_STS, d, n);
         e = ($countones(d & M_STS) == 1) ? (d & M_STS) : 8'h00;
         fw_read(F_STS, v); check_eq("R6 status sweep", {8'd0, v}, {24'd0, e});
         fw_read(F_CTRL, v); check_eq("R4 sweep stale", {8'd0, v}, 2);
         fw_write(F_ACC, 8'h80); fw_write(F_CTRL, 8'h03);
         host_write(A_ACC, d, n);
         e = ($countones(d & M_ACC) == 1) ? (d & M_ACC) : 8'h00;
         fw_read(F_ACC, v); check_eq("R7 access sweep", {8'd0, v}, {24'd0, e});
      end
      fw_write(F_CTRL, 8'h03);

      // R10 foreign addresses
      cs_on(); hdr(1'b1, 6'd0, A_OTH); wait_bytes(4, n, ok);
      check_eq("R10 foreign read held", {31'd0, ok}, 0);
      cs_off();
      fw_read(F_ACC, v0);
      host_write(A_OTH + 24'd4, 8'h02, n);
      check_eq("R10 foreign write one wait", n, 1);
      fw_read(F_CTRL, v); check_eq("R10 no event", {8'd0, v}, 1);
      fw_read(F_ACC, v);  check_eq("R10 access unchanged", v, v0);

      // R12 aborted write
      cs_on(); hdr(1'b0, 6'd0, A_ACC); wait_bytes(4, n, ok);
      spi_bits(8'h04, 4, rx);
      cs_off();
      fw_read(F_ACC, v);  check_eq("R12 access unchanged", v, v0);
      fw_read(F_CTRL, v); check_eq("R12 flags unchanged", {8'd0, v}, 1);
      cs_on(); hdr(1'b1, 6'd0, A_ACC); wait_bytes(4, n, ok);
      check_eq("R12 next read one wait", n, 1);
      spi_bits(8'h00, 8, rx); check_eq("R12 next read data", {24'd0, rx}, {16'd0, v0[7:0]});
      cs_off();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule